// File: doc/BRIEF.md
# DRAM Refresh and Power-State Scheduler

This block sits on the controller side of a DDR memory interface. It decides when a periodic auto-refresh is due and when the clock-enable line may drop for power-down or self-refresh. It also gates the command path while the memory is still recovering. A free-running interval counter adds one owed refresh to a debt counter every `REF_INTERVAL` cycles. With the default of 1040 cycles at 133 MHz, the average is one refresh per 7.8 µs, or 8192 per 64 ms. The debt is offered to the command sequencer through a request/acknowledge handshake while the banks are idle. When the debt reaches its ceiling, the request is forced out regardless of bank state.

The scheduler is a six-state machine:

- **ACTIVE**: normal operation.
- **REFRESH**: the refresh recovery window.
- **PDOWN** and **PD_EXIT**: power-down and the one-cycle wake gap after it.
- **SELFREF** and **SR_EXIT**: self-refresh and the long release after it.

The transitions are:

- ACTIVE→REFRESH on an accepted acknowledge.
- REFRESH→ACTIVE after `RFC_CYC` cycles.
- ACTIVE→SELFREF on a self-refresh entry request while no refresh is owed and the banks are idle.
- ACTIVE→PDOWN on a power-down entry request while no refresh is owed. Self-refresh wins if both requests arrive together.
- PDOWN→PD_EXIT on a power-down exit request.
- PD_EXIT→ACTIVE one cycle later.
- SELFREF→SR_EXIT on a self-refresh exit request.
- SR_EXIT→ACTIVE after `SR_RD_WAIT` cycles.

Every move that toggles clock-enable waits until the line has held its level long enough.

After self-refresh exit there are two release points. Ordinary commands are released after `SR_CMD_WAIT` cycles, and reads only after `SR_RD_WAIT` cycles. No refresh debt accrues while in self-refresh, and the interval counter restarts from zero on exit.

Top module: `dram_pwr_sched`

## Requirements
- R1: After reset the block is ACTIVE: `cke`=1, `cmd_ok`=1, `rd_ok`=1, `ref_req`=0, and no refresh is owed.
- R2: With `banks_idle`=1 and no acknowledge, `ref_req` first rises on the `REF_INTERVAL`-th rising edge after reset release.
- R3: While `banks_idle`=0, `ref_req` stays low until the owed count reaches `MAX_DEBT`; from then on it is asserted whatever `banks_idle` is. Further ticks at the ceiling are not counted.
- R4: A rising edge with `ref_req`=1 and `ref_ack`=1 retires one owed refresh and drops `ref_req` and `cmd_ok`. `cmd_ok` returns on the `RFC_CYC`-th edge after that one.
- R5: While any refresh is owed, power-down and self-refresh entry requests are not acted on (`cke` stays 1).
- R6: A power-down entry request drives `cke` low on the next edge, with `cmd_ok`=`rd_ok`=0 while low. After a power-down exit edge raises `cke`, `cmd_ok` stays low for one cycle and rises on the following edge.
- R7: After any change, `cke` keeps its new level for at least `CKE_HOLD`+1 cycles. An exit request in the first cycle after entry is not acted on.
- R8: Self-refresh entry needs `banks_idle`=1. If self-refresh and power-down entry are requested in the same cycle, self-refresh is taken.
- R9: After the self-refresh exit edge raises `cke`, `cmd_ok` rises on the `SR_CMD_WAIT`-th following edge and `rd_ok` on the `SR_RD_WAIT`-th. `rd_ok`=1 always implies `cmd_ok`=1.
- R10: No refresh is owed for time spent in self-refresh. `ref_req` next rises `REF_INTERVAL` edges after the self-refresh exit edge.
- R11: Exit requests in ACTIVE, the power-down exit request in self-refresh, and `ref_ack` while `ref_req`=0 all have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| pd_enter_req | input | 1 | Request to enter power-down |
| pd_exit_req | input | 1 | Request to leave power-down |
| banks_idle | input | 1 | All banks precharged |
| ref_ack | input | 1 | Sequencer has issued the requested refresh |
| ref_req | output | 1 | A refresh is wanted now |
| cke | output | 1 | Clock-enable to the memory |
| cmd_ok | output | 1 | Non-read commands may be issued |
| rd_ok | output | 1 | Read commands may be issued |

## Verification
Every output is a function of registered state, so a result is due on a known rising edge. Entry, exit and acknowledge results appear one edge after the stimulus. The refresh recovery ends `RFC_CYC` edges after the acknowledge edge. The two self-refresh releases fall `SR_CMD_WAIT` and `SR_RD_WAIT` edges after the exit edge, and the next refresh `REF_INTERVAL` edges after it. Inputs change at the falling edge and outputs are sampled at the next falling edge. For each timed result the bench counts edges from the stimulus edge to the first edge on which the output changes, and compares that count with the parameter. A release that comes early or late by one cycle therefore shows as a wrong count.

// File: rtl/pwrsched_pkg.sv
package pwrsched_pkg;

    typedef enum logic [2:0] {
        PS_ACTIVE  = 3'd0,
        PS_REFRESH = 3'd1,
        PS_PDOWN   = 3'd2,
        PS_PD_EXIT = 3'd3,
        PS_SELFREF = 3'd4,
        PS_SR_EXIT = 3'd5
    } ps_state_e;

endpackage

// File: rtl/ref_debt_tracker.sv
// Interval timer plus saturating count of owed refreshes.
module ref_debt_tracker #(
    parameter int REF_INTERVAL = 1040,
    parameter int MAX_DEBT     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          take,
    output logic [$clog2(MAX_DEBT+1)-1:0] debt,
    output logic                          pending,
    output logic                          full
);
    localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [IW-1:0] I_LAST = IW'(REF_INTERVAL - 1);
    localparam logic [DW-1:0] D_MAX  = DW'(MAX_DEBT);

    logic [IW-1:0] ival_q;
    logic          tick;

    assign tick = run && (ival_q == I_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            ival_q <= '0;
        end else begin
            ival_q <= ival_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (debt != D_MAX) debt <= debt + 1'b1;
                2'b01:   if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign pending = (debt != '0);
    assign full    = (debt == D_MAX);

endmodule

// File: rtl/sched_wait_timer.sv
// Saturating up-counter restarted from zero by clr.
module sched_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cke_hold_guard.sv
// Counts cycles since the last clock-enable change.
module cke_hold_guard #(
    parameter int HOLD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_now,
    input  logic cke_next,
    output logic hold_ok
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] H_MIN = HW'(HOLD);

    logic [HW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= H_MIN;
        end else if (cke_next != cke_now) begin
            since_q <= '0;
        end else if (since_q < H_MIN) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign hold_ok = (since_q >= H_MIN);
endmodule

// File: rtl/dram_pwr_sched.sv
module dram_pwr_sched
    import pwrsched_pkg::*;
#(
    parameter int REF_INTERVAL = 1040,
    parameter int MAX_DEBT     = 8,
    parameter int RFC_CYC      = 10,
    parameter int SR_CMD_WAIT  = 10,
    parameter int SR_RD_WAIT   = 200,
    parameter int CKE_HOLD     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    input  logic pd_enter_req,
    input  logic pd_exit_req,
    input  logic banks_idle,
    input  logic ref_ack,
    output logic ref_req,
    output logic cke,
    output logic cmd_ok,
    output logic rd_ok
);
    localparam int DEBT_W   = $clog2(MAX_DEBT + 1);
    localparam int WAIT_MAX = (SR_RD_WAIT > RFC_CYC) ? SR_RD_WAIT : RFC_CYC;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] RFC_LAST = WAIT_W'(RFC_CYC - 1);
    localparam logic [WAIT_W-1:0] RD_LAST  = WAIT_W'(SR_RD_WAIT - 1);
    localparam logic [WAIT_W-1:0] CMD_MIN  = WAIT_W'(SR_CMD_WAIT);

    ps_state_e             state_q, state_d;
    logic [DEBT_W-1:0]     debt;
    logic                  debt_pend, debt_full;
    logic [WAIT_W-1:0]     wait_cnt;
    logic                  wait_clr;
    logic                  hold_ok;
    logic                  cke_d;
    logic                  ref_take;
    logic                  tick_run;

    assign ref_take = ref_req && ref_ack;
    assign tick_run = (state_q != PS_SELFREF);

    ref_debt_tracker #(
        .REF_INTERVAL(REF_INTERVAL),
        .MAX_DEBT    (MAX_DEBT)
    ) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tick_run),
        .take   (ref_take),
        .debt   (debt),
        .pending(debt_pend),
        .full   (debt_full)
    );

    sched_wait_timer #(.W(WAIT_W)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wait_clr),
        .count(wait_cnt)
    );

    cke_hold_guard #(.HOLD(CKE_HOLD)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke_now (cke),
        .cke_next(cke_d),
        .hold_ok (hold_ok)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ACTIVE: begin
                if (ref_take) begin
                    state_d = PS_REFRESH;
                end else if (!debt_pend && hold_ok) begin
                    if (sr_enter_req && banks_idle) begin
                        state_d = PS_SELFREF;
                    end else if (pd_enter_req) begin
                        state_d = PS_PDOWN;
                    end
                end
            end
            PS_REFRESH: if (wait_cnt == RFC_LAST) state_d = PS_ACTIVE;
            PS_PDOWN:   if (pd_exit_req && hold_ok) state_d = PS_PD_EXIT;
            PS_PD_EXIT: state_d = PS_ACTIVE;
            PS_SELFREF: if (sr_exit_req && hold_ok) state_d = PS_SR_EXIT;
            PS_SR_EXIT: if (wait_cnt == RD_LAST) state_d = PS_ACTIVE;
            default:    state_d = PS_ACTIVE;
        endcase
    end

    assign wait_clr = ((state_q != PS_REFRESH) && (state_d == PS_REFRESH)) ||
                      ((state_q != PS_SR_EXIT) && (state_d == PS_SR_EXIT));
    assign cke_d    = !((state_d == PS_PDOWN) || (state_d == PS_SELFREF));

    // Outputs from the registered state
    always_comb begin
        cke     = 1'b1;
        cmd_ok  = 1'b0;
        rd_ok   = 1'b0;
        ref_req = 1'b0;
        unique case (state_q)
            PS_ACTIVE: begin
                cmd_ok  = 1'b1;
                rd_ok   = 1'b1;
                ref_req = debt_pend && (banks_idle || debt_full);
            end
            PS_REFRESH: ;
            PS_PDOWN:   cke = 1'b0;
            PS_PD_EXIT: ;
            PS_SELFREF: cke = 1'b0;
            PS_SR_EXIT: cmd_ok = (wait_cnt >= CMD_MIN);
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_pwr_sched_chk.sv
module dram_pwr_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic banks_idle,
    input logic ref_ack,
    input logic ref_req,
    input logic cke,
    input logic cmd_ok,
    input logic rd_ok,
    input logic debt_full
);
    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cke) |=> $stable(cke)); // R7

    AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!cmd_ok && !rd_ok && !ref_req)); // R6

    AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_ok); // R6

    AST_READ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> cmd_ok); // R9

    AST_ACK_STARTS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> (!ref_req && !cmd_ok)); // R4

    AST_BUSY_BANKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !banks_idle) |-> debt_full); // R3

    AST_REQ_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (cke && rd_ok)); // R2
endmodule

bind dram_pwr_sched dram_pwr_sched_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .banks_idle(banks_idle),
    .ref_ack   (ref_ack),
    .ref_req   (ref_req),
    .cke       (cke),
    .cmd_ok    (cmd_ok),
    .rd_ok     (rd_ok),
    .debt_full (debt_full)
);

// File: tb/tb_dram_pwr_sched.sv
`timescale 1ns/1ps
module tb_dram_pwr_sched;
    localparam int N    = 64;
    localparam int MAXD = 4;
    localparam int RFC  = 6;
    localparam int SCMD = 10;
    localparam int SRD  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_enter_req = 0, sr_exit_req = 0, pd_enter_req = 0, pd_exit_req = 0;
    logic banks_idle = 0, ref_ack = 0;
    logic ref_req, cke, cmd_ok, rd_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dram_pwr_sched #(
        .REF_INTERVAL(N), .MAX_DEBT(MAXD), .RFC_CYC(RFC),
        .SR_CMD_WAIT(SCMD), .SR_RD_WAIT(SRD), .CKE_HOLD(1)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .pd_enter_req(pd_enter_req), .pd_exit_req(pd_exit_req),
        .banks_idle(banks_idle), .ref_ack(ref_ack),
        .ref_req(ref_req), .cke(cke), .cmd_ok(cmd_ok), .rd_ok(rd_ok)
    );

    // [13:10] requirement, [9:4] sre srx pde pdx idle ack, [3:0] cke cmd rd req
    localparam logic [13:0] VEC [9] = '{
        {4'd6,  6'b001010, 4'b0000},  // R6 enter power-down
        {4'd7,  6'b000110, 4'b0000},  // R7 exit too early, held
        {4'd6,  6'b000110, 4'b1000},  // R6 exit, wake gap
        {4'd6,  6'b000010, 4'b1110},  // R6 commands back
        {4'd11, 6'b010010, 4'b1110},  // R11 exit request in ACTIVE
        {4'd8,  6'b100000, 4'b1110},  // R8 self-refresh needs idle banks
        {4'd8,  6'b101010, 4'b0000},  // R8 self-refresh beats power-down
        {4'd11, 6'b000110, 4'b0000},  // R11 power-down exit in self-refresh
        {4'd9,  6'b010010, 4'b1000}   // R9 self-refresh exit
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int k, k_cmd, k_rd, k_ref;
        logic [3:0] got;
        @(negedge clk);
        repeat (3) tick();
        banks_idle = 1;
        rst_n = 1;
        // R1 reset state
        got = {cke, cmd_ok, rd_ok, ref_req};
        check(got == 4'b1110, "R1 reset outputs", got, 4'b1110);

        // R2 first refresh after N edges
        k = 0;
        while (!ref_req && k < 5*N) begin tick(); k++; end
        check(k == N, "R2 first ref_req edge", k, N);

        // R4 acknowledge and recovery window
        ref_ack = 1;
        tick();
        ref_ack = 0;
        got = {cke, cmd_ok, rd_ok, ref_req};
        check(got == 4'b1000, "R4 after ack", got, 4'b1000);
        k = 0;
        while (!cmd_ok && k < 4*RFC) begin tick(); k++; end
        check(k == RFC, "R4 recovery length", k, RFC);

        // R11 acknowledge without request
        ref_ack = 1;
        tick();
        ref_ack = 0;
        got = {cke, cmd_ok, rd_ok, ref_req};
        check(got == 4'b1110, "R11 stray ack", got, 4'b1110);

        // Vector table
        foreach (VEC[i]) begin
            {sr_enter_req, sr_exit_req, pd_enter_req, pd_exit_req, banks_idle, ref_ack} = VEC[i][9:4];
            tick();
            got = {cke, cmd_ok, rd_ok, ref_req};
            check(got == VEC[i][3:0], $sformatf("R%0d vector %0d", VEC[i][13:10], i), got, VEC[i][3:0]);
        end
        {sr_enter_req, sr_exit_req, pd_enter_req, pd_exit_req, ref_ack} = '0;
        banks_idle = 1;

        // R9 and R10: release points after self-refresh exit
        k_cmd = -1; k_rd = -1; k_ref = -1;
        for (int j = 1; j <= 3*N; j++) begin
            tick();
            if (cmd_ok && k_cmd < 0) k_cmd = j;
            if (rd_ok && k_rd < 0) k_rd = j;
            if (ref_req) begin k_ref = j; break; end
        end
        check(k_cmd == SCMD, "R9 command release", k_cmd, SCMD);
        check(k_rd == SRD, "R9 read release", k_rd, SRD);
        check(k_ref == N, "R10 interval restart", k_ref, N);

        // R3 busy banks withhold until the ceiling
        banks_idle = 0;
        #1;
        check(ref_req == 1'b0, "R3 withheld", ref_req, 0);
        k = 0;
        while (!ref_req && k < (MAXD+1)*N) begin tick(); k++; end
        check(k == (MAXD-1)*N, "R3 forced at ceiling", k, (MAXD-1)*N);

        // R5 entry blocked while refresh owed
        pd_enter_req = 1;
        tick();
        pd_enter_req = 0;
        check(cke == 1'b1, "R5 entry blocked", cke, 1);

        // Drain the owed refreshes
        banks_idle = 1;
        for (int d = 0; d < MAXD; d++) begin
            ref_ack = 1;
            tick();
            ref_ack = 0;
            repeat (RFC) tick();
        end
        check(ref_req == 1'b0, "R4 debt drained", ref_req, 0);

        done = 1;
        finish_run();
    end
endmodule